// File: doc/BRIEF.md
# Debug Serial Port with Register Interface

A small byte-wide serial port meant for console and debug traffic. Software talks to it through a 32-bit word-addressed register port with single-cycle reads and writes. A byte written to the transmit buffer is sent on `txd` as one character of ten bit times: a low start bit, eight data bits least significant first, and a high stop bit. Each bit time lasts `DIV + 1` clock cycles, where `DIV` is a programmable divisor register.

Incoming characters on `rxd` pass through a two-flop synchroniser. A falling edge starts the receiver, which then samples each bit near its middle. A good character lands in a one-deep receive buffer and raises a receive-ready flag. A character whose stop bit reads low is thrown away and raises a framing-error flag instead.

Four status flags are each gated by an interrupt mask bit. The mask is built up through a set-bits register and torn down through a clear-bits register. `irq` is a level output that is high whenever a flag and its mask bit are both set.

Transmitter states: TX_IDLE, TX_START, TX_DATA and TX_STOP. The transitions are:
- TX_IDLE to TX_START on an accepted transmit-buffer write.
- TX_START to TX_DATA when the bit counter expires.
- TX_DATA loops once per data bit, then goes to TX_STOP after the eighth bit.
- TX_STOP to TX_IDLE when the counter expires, which completes the character.

Receiver states: RX_IDLE, RX_START, RX_DATA and RX_STOP. The transitions are:
- RX_IDLE to RX_START on a synchronised falling edge, with a half-bit count loaded.
- RX_START to RX_DATA if the line is still low at mid-bit. If it is high, RX_START returns to RX_IDLE because the start was false.
- RX_DATA loops for eight samples, then goes to RX_STOP.
- RX_STOP to RX_IDLE after the stop sample. That sample reports either a good character or a framing error.

Top module: `dbg_uart`

Register word offsets:
- 0: CTRL, write only.
- 1: IEN, write only.
- 2: IDIS, write only.
- 3: MASK, read only.
- 4: STAT, read only.
- 5: RXBUF, read only.
- 6: TXBUF, write only.
- 7: DIV, read and write.
- 8 to 15: unmapped.

STAT and MASK bit positions:
- Bit 0: receive ready.
- Bit 1: transmit ready.
- Bit 2: transmit empty.
- Bit 3: framing error.

CTRL bits:
- Bit 0: transmitter enable.
- Bit 1: transmitter disable.
- Bit 2: clear framing error.

## Requirements
- R1: After reset, STAT reads 0x6 (transmit ready and transmit empty set), MASK, RXBUF and DIV read 0, `txd` is high and `irq` is low.
- R2: A CTRL write with bit 1 set clears STAT bits 1 and 2. A CTRL write with bit 0 set and bit 1 clear sets them. When both bits are written together, bit 1 wins.
- R3: A TXBUF write is accepted only while STAT bit 1 is set and no character is in flight. An accepted write clears STAT bits 1 and 2 at the same clock edge. Any other TXBUF write is ignored.
- R4: After an accepted TXBUF write at edge E, `txd` carries the start bit, then data bits 0 to 7, then the stop bit. Each bit lasts DIV+1 cycles, starting right after E. STAT bits 1 and 2 are set again at edge E + 10*(DIV+1).
- R5: A good character on `rxd` is stored in RXBUF (bits 7:0) and sets STAT bit 0. A read of RXBUF clears STAT bit 0.
- R6: While STAT bit 0 is set, a newly received character is dropped and RXBUF keeps the unread byte.
- R7: A character whose stop bit samples low leaves RXBUF and STAT bit 0 unchanged and sets STAT bit 3. A CTRL write with bit 2 set clears STAT bit 3.
- R8: An IEN write ORs wdata bits 3:0 into MASK. An IDIS write clears the MASK bits that are set in wdata bits 3:0.
- R9: `irq` is high exactly when MASK AND STAT is nonzero. It follows any change in the same cycle as the change.
- R10: Writes to MASK, STAT, RXBUF and unmapped offsets change nothing. Reads of write-only registers and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | ADDR_W | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes take effect at the edge that samples the strobe. Read data is valid in the same low clock phase as the address, so the bench samples it a few nanoseconds after the falling edge. The bench's behavioural model updates at every rising edge. It counts transmit bit times from the edge that accepts the write, so `txd` and `irq` are compared at every falling edge with no slack. Receive results arrive about 9.5 bit times plus the three-cycle synchroniser and edge-detect delay after the start edge. The bench therefore keeps the receive flags masked while a character is in flight. It updates its expected receive state two bit times after the stop bit ends, and only then reads STAT or RXBUF and unmasks the flags.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

    localparam int unsigned NSTAT = 4;

    // status / mask bit positions
    localparam int unsigned ST_RXRDY = 0;
    localparam int unsigned ST_TXRDY = 1;
    localparam int unsigned ST_TXEMP = 2;
    localparam int unsigned ST_FERR  = 3;

    // control command bits
    localparam int unsigned CT_TXEN  = 0;
    localparam int unsigned CT_TXDIS = 1;
    localparam int unsigned CT_FCLR  = 2;

    // register word offsets
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_IEN   = 1;
    localparam int unsigned OFS_IDIS  = 2;
    localparam int unsigned OFS_MASK  = 3;
    localparam int unsigned OFS_STAT  = 4;
    localparam int unsigned OFS_RXBUF = 5;
    localparam int unsigned OFS_TXBUF = 6;
    localparam int unsigned OFS_DIV   = 7;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

endpackage

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_uart_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [DATA_W-1:0] byte_in,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state, st_n;
    logic [DIV_W-1:0]  cnt, cnt_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [DATA_W-1:0] shreg, sh_n;

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        idx_n = idx;
        sh_n  = shreg;
        unique case (state)
            TX_IDLE: begin
                if (start) begin
                    st_n  = TX_START;
                    cnt_n = div;
                    sh_n  = byte_in;
                end
            end
            TX_START: begin
                if (cnt == '0) begin
                    st_n  = TX_DATA;
                    cnt_n = div;
                    idx_n = '0;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            TX_DATA: begin
                if (cnt == '0) begin
                    cnt_n = div;
                    sh_n  = shreg >> 1;
                    if (idx == LAST_IDX) begin
                        st_n = TX_STOP;
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            TX_STOP: begin
                if (cnt == '0) begin
                    st_n = TX_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
            idx   <= idx_n;
            shreg <= sh_n;
        end
    end

    always_comb begin
        txd  = 1'b1;
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && (cnt == '0);
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import dbg_uart_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd,
    output logic              done,
    output logic              ferr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic              sync1, rx_s, rx_prev;
    rx_state_e         state, st_n;
    logic [DIV_W-1:0]  cnt, cnt_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [DATA_W-1:0] shreg, sh_n;
    logic              fire;

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        idx_n = idx;
        sh_n  = shreg;
        unique case (state)
            RX_IDLE: begin
                if (!rx_s && rx_prev) begin
                    st_n  = RX_START;
                    cnt_n = div >> 1;
                end
            end
            RX_START: begin
                if (cnt == '0) begin
                    if (!rx_s) begin
                        st_n  = RX_DATA;
                        cnt_n = div;
                        idx_n = '0;
                    end else begin
                        st_n = RX_IDLE;
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            RX_DATA: begin
                if (cnt == '0) begin
                    sh_n  = {rx_s, shreg[DATA_W-1:1]};
                    cnt_n = div;
                    if (idx == LAST_IDX) begin
                        st_n = RX_STOP;
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            RX_STOP: begin
                if (cnt == '0) begin
                    st_n = RX_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            rx_s    <= 1'b1;
            rx_prev <= 1'b1;
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
        end else begin
            sync1   <= rxd;
            rx_s    <= sync1;
            rx_prev <= rx_s;
            state   <= st_n;
            cnt     <= cnt_n;
            idx     <= idx_n;
            shreg   <= sh_n;
        end
    end

    always_comb begin
        fire = (state == RX_STOP) && (cnt == '0);
        done = fire && rx_s;
        ferr = fire && !rx_s;
        data = shreg;
    end

endmodule

// File: rtl/dbg_uart_regs.sv
module dbg_uart_regs
    import dbg_uart_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              tx_done,
    input  logic              tx_busy,
    input  logic              rx_done,
    input  logic              rx_ferr,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DIV_W-1:0]  div,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    output logic [NSTAT-1:0]  stat,
    output logic [NSTAT-1:0]  mask,
    output logic [DATA_W-1:0] rx_buf,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(OFS_IDIS);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_RXBUF = ADDR_W'(OFS_RXBUF);
    localparam logic [ADDR_W-1:0] A_TXBUF = ADDR_W'(OFS_TXBUF);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFS_DIV);
    localparam logic [NSTAT-1:0]  STAT_RST = NSTAT'((1 << ST_TXRDY) | (1 << ST_TXEMP));

    logic [NSTAT-1:0] stat_n;
    logic             wr_ctrl, rd_rxbuf, rx_accept;
    logic             wdata_unused;

    assign wdata_unused = ^wdata;
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign rd_rxbuf  = rd_en && (addr == A_RXBUF);
    assign tx_start  = wr_en && (addr == A_TXBUF) && stat[ST_TXRDY] && !tx_busy;
    assign tx_byte   = wdata[DATA_W-1:0];
    assign rx_accept = rx_done && !stat[ST_RXRDY];

    always_comb begin
        stat_n = stat;
        if (tx_done) begin
            stat_n[ST_TXRDY] = 1'b1;
            stat_n[ST_TXEMP] = 1'b1;
        end
        if (wr_ctrl) begin
            if (wdata[CT_TXDIS]) begin
                stat_n[ST_TXRDY] = 1'b0;
                stat_n[ST_TXEMP] = 1'b0;
            end else if (wdata[CT_TXEN]) begin
                stat_n[ST_TXRDY] = 1'b1;
                stat_n[ST_TXEMP] = 1'b1;
            end
        end
        if (tx_start) begin
            stat_n[ST_TXRDY] = 1'b0;
            stat_n[ST_TXEMP] = 1'b0;
        end
        if (rx_ferr) stat_n[ST_FERR] = 1'b1;
        if (wr_ctrl && wdata[CT_FCLR]) stat_n[ST_FERR] = 1'b0;
        if (rd_rxbuf) stat_n[ST_RXRDY] = 1'b0;
        if (rx_accept) stat_n[ST_RXRDY] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat   <= STAT_RST;
            mask   <= '0;
            rx_buf <= '0;
            div    <= '0;
        end else begin
            stat <= stat_n;
            if (wr_en && addr == A_IEN)  mask <= mask | wdata[NSTAT-1:0];
            if (wr_en && addr == A_IDIS) mask <= mask & ~wdata[NSTAT-1:0];
            if (wr_en && addr == A_DIV)  div  <= wdata[DIV_W-1:0];
            if (rx_accept) rx_buf <= rx_data;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MASK:  rdata = BUS_W'(mask);
            A_STAT:  rdata = BUS_W'(stat);
            A_RXBUF: rdata = BUS_W'(rx_buf);
            A_DIV:   rdata = BUS_W'(div);
            default: rdata = '0;
        endcase
    end

    assign irq = |(mask & stat);

endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
    import dbg_uart_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    localparam int unsigned BUS_W = 32;

    logic [DIV_W-1:0]  div;
    logic              tx_start, tx_busy, tx_done;
    logic [DATA_W-1:0] tx_byte;
    logic              rx_done, rx_ferr;
    logic [DATA_W-1:0] rx_data;
    logic [NSTAT-1:0]  stat, mask;
    logic [DATA_W-1:0] rx_buf;

    dbg_uart_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_done(tx_done), .tx_busy(tx_busy),
        .rx_done(rx_done), .rx_ferr(rx_ferr), .rx_data(rx_data), .div(div),
        .tx_start(tx_start), .tx_byte(tx_byte), .stat(stat), .mask(mask),
        .rx_buf(rx_buf), .irq(irq)
    );

    dbg_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(div), .start(tx_start), .byte_in(tx_byte),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    dbg_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(div), .rxd(rxd),
        .done(rx_done), .ferr(rx_ferr), .data(rx_data)
    );

endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk
    import dbg_uart_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              txd,
    input logic              irq,
    input logic [NSTAT-1:0]  stat,
    input logic [NSTAT-1:0]  mask,
    input logic [DATA_W-1:0] rx_buf,
    input logic              tx_busy
);
    localparam logic [ADDR_W-1:0] C_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] C_IEN   = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] C_IDIS  = ADDR_W'(OFS_IDIS);
    localparam logic [ADDR_W-1:0] C_RXBUF = ADDR_W'(OFS_RXBUF);
    localparam logic [ADDR_W-1:0] C_TXBUF = ADDR_W'(OFS_TXBUF);

    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_CTRL && wdata[CT_TXDIS]) |=> (!stat[ST_TXRDY] && !stat[ST_TXEMP]));

    a_r3_txbuf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_TXBUF && stat[ST_TXRDY] && !tx_busy) |=> (!stat[ST_TXRDY] && !stat[ST_TXEMP]));

    a_r4_start_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> !stat[ST_TXRDY]);

    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_RXRDY] && !(rd_en && addr == C_RXBUF)) |=> $stable(rx_buf));

    a_r8_ien_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_IEN) |=> ((mask & $past(wdata[NSTAT-1:0])) == $past(wdata[NSTAT-1:0])));

    a_r8_idis_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_IDIS) |=> ((mask & $past(wdata[NSTAT-1:0])) == '0));

    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind dbg_uart dbg_uart_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .txd(txd), .irq(irq), .stat(stat), .mask(mask),
    .rx_buf(rx_buf), .tx_busy(tx_busy)
);

// File: tb/tb_dbg_uart.sv
`timescale 1ns/1ps
module tb_dbg_uart;
    localparam int BT = 8;  // bit time used in the bench, DIV = BT-1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rxd = 1'b1;
    logic        txd, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural model state
    logic       m_rxr, m_txr, m_txe, m_fe, m_busy;
    logic [3:0] m_mask;
    logic [7:0] m_rxd, m_byte;
    logic [15:0] m_div;
    int         m_k, m_B;

    dbg_uart dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

    always #10 clk = ~clk;

    function automatic logic [3:0] m_stat();
        return {m_fe, m_txe, m_txr, m_rxr};
    endfunction

    function automatic logic m_txd();
        int bi;
        if (!m_busy) return 1'b1;
        bi = m_k / m_B;
        if (bi == 0) return 1'b0;
        if (bi >= 9) return 1'b1;
        return m_byte[bi-1];
    endfunction

    always @(posedge clk) begin
        logic txr_pre, busy_pre;
        if (!rst_n) begin
            m_rxr = 0; m_txr = 1; m_txe = 1; m_fe = 0; m_busy = 0;
            m_mask = '0; m_rxd = '0; m_byte = '0; m_div = '0; m_k = 0; m_B = 1;
        end else begin
            txr_pre  = m_txr;
            busy_pre = m_busy;
            if (m_busy) begin
                if (m_k == 10 * m_B - 1) begin
                    m_busy = 0; m_txr = 1; m_txe = 1;
                end else begin
                    m_k++;
                end
            end
            if (wr_en) begin
                case (addr)
                    4'd0: begin
                        if (wdata[1]) begin m_txr = 0; m_txe = 0; end
                        else if (wdata[0]) begin m_txr = 1; m_txe = 1; end
                        if (wdata[2]) m_fe = 0;
                    end
                    4'd1: m_mask = m_mask | wdata[3:0];
                    4'd2: m_mask = m_mask & ~wdata[3:0];
                    4'd6: if (txr_pre && !busy_pre) begin
                        m_busy = 1; m_k = 0; m_B = int'(m_div) + 1;
                        m_byte = wdata[7:0]; m_txr = 0; m_txe = 0;
                    end
                    4'd7: m_div = wdata[15:0];
                    default: ;
                endcase
            end
            if (rd_en && addr == 4'd5) m_rxr = 0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the serial line and interrupt
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 txd", {31'd0, txd}, {31'd0, m_txd()});
            check("R9 irq", {31'd0, irq}, {31'd0, |(m_mask & m_stat())});
        end
    end

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic check_read(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2;
        check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drive_bit(logic v);
        rxd = v;
        repeat (BT) @(negedge clk);
    endtask

    task automatic send_rx(logic [7:0] b, logic stop_ok);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop_ok);
        rxd = 1'b1;
        repeat (2 * BT) @(negedge clk);
        #3;
        if (stop_ok) begin
            if (!m_rxr) begin m_rxr = 1; m_rxd = b; end
        end else begin
            m_fe = 1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_read("R1 stat", 4'd4, 32'h6);
        check_read("R1 mask", 4'd3, 32'h0);
        check_read("R1 rxbuf", 4'd5, 32'h0);
        check_read("R1 div", 4'd7, 32'h0);
        check("R1 txd", {31'd0, txd}, 32'd1);
        // R10 ignored writes and unmapped reads
        check_read("R10 unmapped", 4'd9, 32'h0);
        check_read("R10 ctrl wo", 4'd0, 32'h0);
        bus_write(4'd4, 32'hF);
        check_read("R10 stat ro", 4'd4, 32'h6);
        bus_write(4'd3, 32'hF);
        check_read("R10 mask ro", 4'd3, 32'h0);
        bus_write(4'd9, 32'hFF);
        check_read("R10 div untouched", 4'd7, 32'h0);
        bus_write(4'd7, BT - 1);
        check_read("R10 div rw", 4'd7, BT - 1);
        // R8 mask set / clear
        bus_write(4'd1, 32'h2);
        check_read("R8 ien", 4'd3, 32'h2);
        check("R9 irq tx ready", {31'd0, irq}, 32'd1);
        bus_write(4'd2, 32'h2);
        check_read("R8 idis", 4'd3, 32'h0);
        bus_write(4'd1, 32'hF);
        bus_write(4'd2, 32'h9);
        check_read("R8 partial", 4'd3, 32'h6);
        // R3/R4 transmit with busy write ignored
        bus_write(4'd6, 32'hA5);
        check_read("R3 flags cleared", 4'd4, 32'h0);
        bus_write(4'd6, 32'h3C);
        repeat (10 * BT + 4) @(negedge clk);
        check_read("R4 flags back", 4'd4, 32'h6);
        bus_write(4'd6, 32'h01);
        repeat (10 * BT + 2) @(negedge clk);
        bus_write(4'd6, 32'h80);
        repeat (10 * BT + 2) @(negedge clk);
        // R2 enable/disable
        bus_write(4'd0, 32'h2);
        check_read("R2 disable", 4'd4, 32'h0);
        bus_write(4'd6, 32'h55);
        repeat (BT) @(negedge clk);
        check("R3 ignored while disabled", {31'd0, txd}, 32'd1);
        bus_write(4'd0, 32'h1);
        check_read("R2 enable", 4'd4, 32'h6);
        bus_write(4'd0, 32'h3);
        check_read("R2 disable wins", 4'd4, 32'h0);
        bus_write(4'd0, 32'h1);
        // R5 receive
        bus_write(4'd2, 32'hF);
        send_rx(8'h5A, 1'b1);
        check_read("R5 rx ready", 4'd4, 32'h7);
        bus_write(4'd1, 32'h1);
        check("R9 irq rx", {31'd0, irq}, 32'd1);
        check_read("R5 rxbuf", 4'd5, 32'h5A);
        check_read("R5 cleared", 4'd4, 32'h6);
        bus_write(4'd2, 32'h1);
        // R6 overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        check_read("R6 kept", 4'd5, 32'h11);
        check_read("R6 stat", 4'd4, 32'h6);
        // R7 framing error
        send_rx(8'h33, 1'b0);
        check_read("R7 ferr", 4'd4, 32'hE);
        check_read("R7 rxbuf kept", 4'd5, 32'h11);
        bus_write(4'd1, 32'h8);
        check("R7 irq ferr", {31'd0, irq}, 32'd1);
        bus_write(4'd0, 32'h4);
        check_read("R7 ferr clear", 4'd4, 32'h6);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule